// File: doc/BRIEF.md
# Daisy-Chained Interrupt Requester

The block raises an interrupt on one backplane request line on behalf of local user logic, then takes part in the interrupt-acknowledge daisy chain. Software sets a single level from 1 to 7. That level selects the request line the block drives, and the same value is compared against the level the handler acknowledges on address lines A1..A3. The request and the acknowledge levels therefore cannot disagree. Level 0 switches the requester off.

When an acknowledge cycle reaches the block, two things decide the outcome: whether the acknowledged level equals the configured level, and whether a request is pending. If both hold, the block answers. It drives a 16-bit status/ID word, asserts the data acknowledge, and pulses an active-low acknowledge to the user logic for the duration of the cycle. In every other case it hands the chain on to the next board downstream. The downstream output is gated by the address strobe and by the upstream chain input, so it releases as soon as either one ends.

The request input is level-sensitive. If the user logic keeps it high past the end of the acknowledge pulse, a second interrupt is raised.

Top module: `irq_responder`

## Requirements
- R1: One clock edge after `req_i` is sampled high with `level_i` = L in 1..7, `irq_no[L-1]` is low and every other bit of `irq_no` is high. Bit i of `irq_no` stands for level i+1.
- R2: One clock edge after `req_i` is sampled low, all bits of `irq_no` are high.
- R3: An acknowledge cycle starts at a clock edge where `iack_ni`, `iackin_ni` and `as_ni` are low and at least one bit of `ds_ni` is low. If `addr_i` equals the level, the level is nonzero and a request is pending, then from the next edge `piack_no` and `dtack_no` are low, `data_oe_o` is high, and `data_o` carries the `status_id_i` value sampled at the start edge.
- R4: During a response, `data_o` stays stable even if `status_id_i` changes. The edge that first samples both `ds_ni` bits high releases the response: after it, `piack_no` and `dtack_no` are high, `data_oe_o` is low and `data_o` is zero.
- R5: An acknowledge cycle with a wrong level, or with no request pending, drives `iackout_no` low from the next edge. `piack_no` and `dtack_no` stay high and `data_oe_o` stays low.
- R6: `iackout_no` is high whenever `as_ni` or `iackin_ni` is high, with no clock edge needed. It is never low at the same time as `piack_no`.
- R7: With `level_i` = 0 the block never drives a request line and never responds. Every acknowledge cycle is passed downstream.
- R8: If `req_i` stays high through a response, the request line stays asserted, and the next acknowledge cycle at that level is answered again.
- R9: While `rst_ni` is low, every active-low output is high, `data_oe_o` is low and `data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 3 | Configured interrupt level, 0 = off |
| req_i | input | 1 | User interrupt request, active high |
| status_id_i | input | 16 | Status/ID word supplied by user logic |
| iack_ni | input | 1 | Bus interrupt-acknowledge cycle, active low |
| iackin_ni | input | 1 | Daisy-chain input from upstream, active low |
| as_ni | input | 1 | Address strobe, active low |
| ds_ni | input | 2 | Data strobes, active low |
| addr_i | input | 3 | Acknowledged level from A1..A3 |
| irq_no | output | 7 | Request lines for levels 1..7, active low |
| iackout_no | output | 1 | Daisy-chain output to downstream, active low |
| piack_no | output | 1 | Acknowledge pulse to user logic, active low |
| dtack_no | output | 1 | Data transfer acknowledge, active low |
| data_o | output | 16 | Status/ID word, zero when not driven |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The assertions check the invariants that hold on every cycle:
- at most one request line is low;
- the user acknowledge and the data acknowledge are asserted together;
- the responded word stays stable;
- the downstream chain output is never low without a low address strobe and a low chain input, and never alongside the user acknowledge;
- the response is released after both strobes rise.

Only the bench scenarios can show that the right outcome was chosen. They sweep every level against every acknowledged level, with and without a pending request. That sweep is what shows whether the cycle was answered or passed on, that the answered word is the one sampled at the start, and that a request held too long produces a second answer.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned LEVELS = 7;
  localparam int unsigned LVL_W  = $clog2(LEVELS + 1);
  localparam int unsigned DATA_W = 16;
  localparam int unsigned DS_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RESP = 2'd1,
    ST_PASS = 2'd2,
    ST_DONE = 2'd3
  } ack_state_e;
endpackage

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int unsigned LEVELS = irq_pkg::LEVELS,
  parameter int unsigned LVL_W  = irq_pkg::LVL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              req_i,
  output logic [LEVELS-1:0] irq_no,
  output logic              pending_o
);
  logic [LEVELS-1:0] irq_q;

  for (genvar g = 0; g < LEVELS; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[g] <= 1'b1;
      else         irq_q[g] <= ~(req_i && (level_i == LVL_W'(g + 1)));
    end
  end

  assign irq_no    = irq_q;
  assign pending_o = ~&irq_q;

  // R1: never more than one line driven
  a_r1_single_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~irq_no));

  // R2: dropped request clears every line
  a_r2_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> &irq_no);
endmodule

// File: rtl/ack_match.sv
module ack_match #(
  parameter int unsigned LVL_W = irq_pkg::LVL_W,
  parameter int unsigned DS_W  = irq_pkg::DS_W
) (
  input  logic             iack_ni,
  input  logic             iackin_ni,
  input  logic             as_ni,
  input  logic [DS_W-1:0]  ds_ni,
  input  logic [LVL_W-1:0] addr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             pending_i,
  output logic             start_o,
  output logic             match_o
);
  assign start_o = !iack_ni && !iackin_ni && !as_ni && !(&ds_ni);
  assign match_o = pending_i && (level_i != '0) && (addr_i == level_i);
endmodule

// File: rtl/ack_fsm.sv
module ack_fsm
  import irq_pkg::*;
#(
  parameter int unsigned DATA_W = irq_pkg::DATA_W,
  parameter int unsigned DS_W   = irq_pkg::DS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              match_i,
  input  logic              as_ni,
  input  logic              iackin_ni,
  input  logic [DS_W-1:0]   ds_ni,
  input  logic [DATA_W-1:0] word_i,
  output logic              iackout_no,
  output logic              piack_no,
  output logic              dtack_no,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  ack_state_e        state_q, state_d;
  logic [DATA_W-1:0] word_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = match_i ? ST_RESP : ST_PASS;
      ST_RESP: if (&ds_ni)  state_d = ST_DONE;
      ST_PASS: if (as_ni)   state_d = ST_IDLE;
      ST_DONE: if (as_ni)   state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i && match_i) word_q <= word_i;
    end
  end

  wire resp = (state_q == ST_RESP);

  // strobe gating releases the chain without waiting for a clock edge
  assign iackout_no = !((state_q == ST_PASS) && !as_ni && !iackin_ni);
  assign piack_no   = !resp;
  assign dtack_no   = !resp;
  assign data_oe_o  = resp;
  assign data_o     = resp ? word_q : '0;

  a_r3_ack_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (piack_no == dtack_no) && (data_oe_o == !dtack_no));

  a_r4_word_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && (&ds_ni)) |=> (dtack_no && !data_oe_o));

  a_r6_chain_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iackout_no |-> (!as_ni && !iackin_ni && piack_no));
endmodule

// File: rtl/irq_responder.sv
module irq_responder
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              req_i,
  input  logic [DATA_W-1:0] status_id_i,
  input  logic              iack_ni,
  input  logic              iackin_ni,
  input  logic              as_ni,
  input  logic [DS_W-1:0]   ds_ni,
  input  logic [LVL_W-1:0]  addr_i,
  output logic [LEVELS-1:0] irq_no,
  output logic              iackout_no,
  output logic              piack_no,
  output logic              dtack_no,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic pending, start, match;

  irq_line_drv #(.LEVELS(LEVELS), .LVL_W(LVL_W)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level_i), .req_i(req_i),
    .irq_no(irq_no), .pending_o(pending)
  );

  ack_match #(.LVL_W(LVL_W), .DS_W(DS_W)) u_match (
    .iack_ni(iack_ni), .iackin_ni(iackin_ni), .as_ni(as_ni), .ds_ni(ds_ni),
    .addr_i(addr_i), .level_i(level_i), .pending_i(pending),
    .start_o(start), .match_o(match)
  );

  ack_fsm #(.DATA_W(DATA_W), .DS_W(DS_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .match_i(match),
    .as_ni(as_ni), .iackin_ni(iackin_ni), .ds_ni(ds_ni), .word_i(status_id_i),
    .iackout_no(iackout_no), .piack_no(piack_no), .dtack_no(dtack_no),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  // R7: a disabled requester never answers
  a_r7_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == '0 && $stable(level_i)) |=> (&irq_no));
endmodule

// File: tb/irq_responder_bench.sv
module irq_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  level = '0;
  logic        req = 1'b0;
  logic [15:0] sid = '0;
  logic        iack_n = 1'b1, iackin_n = 1'b1, as_n = 1'b1;
  logic [1:0]  ds_n = 2'b11;
  logic [2:0]  addr = '0;
  logic [6:0]  irq_n;
  logic        iackout_n, piack_n, dtack_n, oe;
  logic [15:0] data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irq_responder u_irq_responder (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .req_i(req),
    .status_id_i(sid), .iack_ni(iack_n), .iackin_ni(iackin_n), .as_ni(as_n),
    .ds_ni(ds_n), .addr_i(addr), .irq_no(irq_n), .iackout_no(iackout_n),
    .piack_no(piack_n), .dtack_no(dtack_n), .data_o(data), .data_oe_o(oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_irq(input logic [2:0] l, input logic r);
    exp_irq = 7'h7f;
    if (r && l != 0) exp_irq[l-1] = 1'b0;
  endfunction

  task automatic ack_cycle(input logic [2:0] a, input bit answer, input logic [15:0] w);
    @(negedge clk); iack_n = 0; iackin_n = 0; addr = a; as_n = 0;
    @(negedge clk); ds_n = 2'b00;
    @(negedge clk);
    if (answer) begin
      chk(!piack_n && !dtack_n && oe, "R3 ack outputs", {piack_n, dtack_n, oe}, 3'b001);
      chk(data == w, "R3 word", data, w);
      chk(iackout_n, "R6 no chain on answer", iackout_n, 1);
      sid = ~w;
      @(negedge clk);
      chk(data == w, "R4 word stable", data, w);
      ds_n = 2'b11;
      @(negedge clk);
      chk(piack_n && dtack_n && !oe && data == 0, "R4 release",
          {piack_n, dtack_n, oe, data}, {2'b11, 1'b0, 16'h0});
      as_n = 1;
    end else begin
      chk(!iackout_n, "R5 chain passed", iackout_n, 0);
      chk(piack_n && dtack_n && !oe, "R5 silent", {piack_n, dtack_n, oe}, 3'b110);
      as_n = 1;
      #1;
      chk(iackout_n, "R6 release on AS", iackout_n, 1);
      ds_n = 2'b11;
    end
    iack_n = 1; iackin_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_n == 7'h7f && iackout_n && piack_n && dtack_n && !oe && data == 0,
        "R9 reset", {irq_n, iackout_n, piack_n, dtack_n, oe}, {7'h7f, 4'b1110});
    rst_n = 1;
    for (int l = 0; l < 8; l++) begin
      for (int a = 1; a < 8; a++) begin
        for (int r = 0; r < 2; r++) begin
          logic [15:0] w;
          bit ans;
          w = 16'(l * 256 + a * 16 + r + 16'h1000);
          @(negedge clk); level = 3'(l); req = r[0]; sid = w;
          @(negedge clk);
          chk(irq_n == exp_irq(3'(l), r[0]), l == 0 ? "R7 no line" : "R1 line",
              irq_n, exp_irq(3'(l), r[0]));
          ans = (l != 0) && (a == l) && (r == 1);
          ack_cycle(3'(a), ans, w);
          req = 0;
          @(negedge clk);
          chk(irq_n == 7'h7f, "R2 drop", irq_n, 7'h7f);
        end
      end
    end
    // R8: request held through the answer triggers a second one
    @(negedge clk); level = 3'd3; req = 1; sid = 16'hbeef;
    @(negedge clk);
    ack_cycle(3'd3, 1'b1, 16'hbeef);
    chk(irq_n == exp_irq(3'd3, 1), "R8 line kept", irq_n, exp_irq(3'd3, 1));
    sid = 16'h1234;
    ack_cycle(3'd3, 1'b1, 16'h1234);
    req = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule